// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block generates a single pulse-width modulated output whose duty values come from a small queue. A counter steps from zero to one below a programmable period and then starts again. The output is high while the counter is below the active duty and low for the rest of the period. Software-style writes push duty samples into a four-entry queue. At every period boundary one queued sample becomes the active duty.

A duty change can therefore never cut into a period already in progress. If a smaller duty took effect after the counter had already passed it, the output would stay high for the whole period. Here, a write that finds the queue empty waits for the next period boundary. When the queue is empty at a boundary, the last duty repeats.

Status outputs report the queue fill level, the live counter and a sticky flag for writes lost to a full queue. An enable input parks the counter and the output. Raising the enable empties the queue.

Top module: `qpwm_top`

## Requirements
- R1: After reset, pwm_o is 0, cnt_o is 0, level_o is 0 and ovf_o is 0.
- R2: While enabled with period value P >= 2, cnt_o takes the values 0, 1, …, P-1 and then returns to 0, so each period lasts P cycles. With P <= 1, cnt_o stays at 0 and every cycle is a period boundary.
- R3: Within a period whose active duty is D, pwm_o is 1 exactly in the cycles where cnt_o < D. So a period holds min(D, P) high cycles: D = 0 gives a constantly low output, and D >= P gives a constantly high output.
- R4: The queue holds 4 samples. One sample is taken, oldest first, at each period boundary, and it is the active duty from the cycle in which cnt_o reads 0. level_o gives the number of queued samples.
- R5: A write never changes the period in progress. A write that lands on the clock edge that ends a period (cnt_o = P-1 with an empty queue) becomes active one full period later.
- R6: If the queue is empty at a period boundary, the previous active duty is kept for the next period.
- R7: A write while level_o = 4 is dropped and sets ovf_o on the next edge. ovf_o stays set until ovf_clr_i is high for one cycle, and a new drop in the same cycle wins over the clear.
- R8: One edge after en_i goes low, cnt_o is 0 and pwm_o is 0, and both stay so while en_i stays low.
- R9: On the first edge with en_i high after it was low, the queue is emptied and a write in that cycle is dropped without setting ovf_o. The active duty is kept, and the counter starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| period_i | input | CNT_W | Period length in cycles |
| wr_en_i | input | 1 | Push a duty sample |
| wr_duty_i | input | CNT_W | Duty sample to push |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| pwm_o | output | 1 | Modulated output |
| cnt_o | output | CNT_W | Live counter value |
| level_o | output | $clog2(DEPTH+1) | Samples waiting in the queue |
| ovf_o | output | 1 | Sticky dropped-write flag |

## Verification
Every result is registered, so each one appears one edge after its cause:
- level_o and ovf_o change one edge after a write.
- cnt_o and pwm_o settle one edge after a change of en_i.
- A queued duty appears in the first cycle where cnt_o reads 0 after the boundary that consumed it.

Inputs change on the falling edge, and outputs are sampled on the falling edge before the next rising edge. Each period is therefore measured from that cnt_o = 0 cycle, over exactly P samples. The boundary-write case puts the write in the cnt_o = P-1 cycle and expects the old duty for one more whole period.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  parameter int unsigned QPWM_CNT_W = 16;
  parameter int unsigned QPWM_DEPTH = 4;

  typedef enum logic [1:0] {
    FQ_HOLD = 2'b00,
    FQ_POP  = 2'b01,
    FQ_PUSH = 2'b10,
    FQ_BOTH = 2'b11
  } fq_op_e;
endpackage

// File: rtl/qpwm_fifo.sv
module qpwm_fifo
  import qpwm_pkg::*;
#(
  parameter int unsigned W     = QPWM_CNT_W,
  parameter int unsigned DEPTH = QPWM_DEPTH,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          drop_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_n, rd_ptr_n;
  logic [LW-1:0] cnt_q;
  logic          full, push_ok, pop_ok;
  fq_op_e        op;

  assign full    = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;
  assign drop_o  = push_i & full & ~flush_i;
  assign op      = fq_op_e'({push_ok, pop_ok});

  generate
    if ((DEPTH & (DEPTH - 1)) == 0 && DEPTH > 1) begin : g_pow2
      assign wr_ptr_n = wr_ptr_q + AW'(1);
      assign rd_ptr_n = rd_ptr_q + AW'(1);
    end else begin : g_mod
      assign wr_ptr_n = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
      assign rd_ptr_n = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_n;
      if (pop_ok)  rd_ptr_q <= rd_ptr_n;
      case (op)
        FQ_PUSH: cnt_q <= cnt_q + LW'(1);
        FQ_POP:  cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = cnt_q;

  a_r4_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH));
  a_r7_drop_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !flush_i) |=> $stable(cnt_q));
  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0));
endmodule

// File: rtl/qpwm_core.sv
module qpwm_core
  import qpwm_pkg::*;
#(
  parameter int unsigned W = QPWM_CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] period_i,
  input  logic         load_valid_i,
  input  logic [W-1:0] load_duty_i,
  output logic         pop_o,
  output logic         start_o,
  output logic         pwm_o,
  output logic [W-1:0] cnt_o
);
  logic         run_q;
  logic [W-1:0] cnt_q, duty_q;
  logic [W:0]   cnt_inc;
  logic         wrap, tick;

  assign cnt_inc = {1'b0, cnt_q} + (W+1)'(1);
  // >= so a period shrunk below the count still wraps at once
  assign wrap    = (cnt_inc >= {1'b0, period_i});
  assign tick    = run_q & en_i & wrap;
  assign start_o = en_i & ~run_q;
  assign pop_o   = tick & load_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      run_q <= en_i;
      if (!en_i || !run_q || wrap) cnt_q <= '0;
      else                         cnt_q <= cnt_inc[W-1:0];
      if (pop_o) duty_q <= load_duty_i;
    end
  end

  assign pwm_o = run_q & (cnt_q < duty_q);
  assign cnt_o = cnt_q;

  a_r5_duty_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(duty_q));
  a_r8_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_o == '0 && !pwm_o));
  a_r2_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (cnt_o == '0));
endmodule

// File: rtl/qpwm_top.sv
module qpwm_top
  import qpwm_pkg::*;
#(
  parameter int unsigned CNT_W = QPWM_CNT_W,
  parameter int unsigned DEPTH = QPWM_DEPTH,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_duty_i,
  input  logic             ovf_clr_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [LW-1:0]    level_o,
  output logic             ovf_o
);
  logic             pop, start, empty, drop;
  logic [CNT_W-1:0] head;
  logic             ovf_q;

  qpwm_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (start),
    .push_i  (wr_en_i),
    .data_i  (wr_duty_i),
    .pop_i   (pop),
    .data_o  (head),
    .level_o (level_o),
    .empty_o (empty),
    .drop_o  (drop)
  );

  qpwm_core #(.W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .period_i     (period_i),
    .load_valid_i (~empty),
    .load_duty_i  (head),
    .pop_o        (pop),
    .start_o      (start),
    .pwm_o        (pwm_o),
    .cnt_o        (cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (drop)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end
  assign ovf_o = ovf_q;

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  a_r7_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> ovf_o);
endmodule

// File: tb/qpwm_top_tb_top.sv
module qpwm_top_tb_top;
  localparam int W  = 16;
  localparam int LW = 3;
  localparam int VEC_N = 9;
  localparam int VEC_P [VEC_N] = '{10, 10, 10, 10, 8, 8, 5, 1, 10};
  localparam int VEC_D [VEC_N] = '{ 3,  0, 10, 15, 1, 7, 2, 1,  8};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [W-1:0] period_i = 16'd10;
  logic wr_en_i = 1'b0;
  logic [W-1:0] wr_duty_i = '0;
  logic ovf_clr_i = 1'b0;
  logic pwm_o, ovf_o;
  logic [W-1:0] cnt_o;
  logic [LW-1:0] level_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  qpwm_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .period_i(period_i),
    .wr_en_i(wr_en_i), .wr_duty_i(wr_duty_i), .ovf_clr_i(ovf_clr_i),
    .pwm_o(pwm_o), .cnt_o(cnt_o), .level_o(level_o), .ovf_o(ovf_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // measure P cycles from a cnt_o==0 sample; ends on the next period's first sample
  task automatic measure(input int p, input int exp_hi, input string tag);
    int hi = 0;
    bit cnt_ok = 1'b1;
    for (int i = 0; i < p; i++) begin
      if (cnt_o != W'(i)) cnt_ok = 1'b0;
      if (pwm_o) hi++;
      @(negedge clk);
    end
    check(cnt_ok, "R2 counter sequence", int'(cnt_o), 0);
    check(hi == exp_hi, tag, hi, exp_hi);
  endtask

  task automatic wait_cnt0();
    for (int g = 0; g < 1000 && cnt_o != 0; g++) @(negedge clk);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(pwm_o == 0, "R1 pwm reset", int'(pwm_o), 0);
    check(cnt_o == 0, "R1 cnt reset", int'(cnt_o), 0);
    check(level_o == 0, "R1 level reset", int'(level_o), 0);
    check(ovf_o == 0, "R1 ovf reset", int'(ovf_o), 0);
    repeat (3) @(negedge clk);
    check(cnt_o == 0, "R8 parked before enable", int'(cnt_o), 0);

    en_i = 1'b1;
    @(negedge clk);

    // table walk: R3 high count = min(D,P), R2 count sequence
    for (int v = 0; v < VEC_N; v++) begin
      period_i  = W'(VEC_P[v]);
      wr_en_i   = 1'b1;
      wr_duty_i = W'(VEC_D[v]);
      @(negedge clk);
      wr_en_i = 1'b0;
      for (int g = 0; g < 1000 && level_o != 0; g++) @(negedge clk);
      check(cnt_o == 0, "R4 load at boundary", int'(cnt_o), 0);
      measure(VEC_P[v], (VEC_D[v] < VEC_P[v]) ? VEC_D[v] : VEC_P[v], "R3 high cycles");
    end

    // R6: empty queue repeats duty 8
    check(level_o == 0, "R6 queue empty", int'(level_o), 0);
    measure(10, 8, "R6 duty repeated");

    // R5: write 3 at cnt 6, current period unchanged (8), next gives 3
    begin
      int hi = 0;
      for (int i = 0; i < 10; i++) begin
        if (pwm_o) hi++;
        wr_en_i   = (i == 6);
        wr_duty_i = 16'd3;
        @(negedge clk);
      end
      wr_en_i = 1'b0;
      check(hi == 8, "R5 mid-period write no effect", hi, 8);
    end
    measure(10, 3, "R5 new duty next period");

    // R5: write 6 on the last cycle of a period
    for (int i = 0; i < 10; i++) begin
      wr_en_i   = (i == 9);
      wr_duty_i = 16'd6;
      @(negedge clk);
    end
    wr_en_i = 1'b0;
    check(level_o == 1, "R5 boundary write still queued", int'(level_o), 1);
    measure(10, 3, "R5 old duty one more period");
    measure(10, 6, "R5 boundary write applied");

    // R4/R7: five writes, last one dropped
    begin
      int vals [5] = '{1, 4, 7, 9, 5};
      for (int i = 0; i < 5; i++) begin
        wr_en_i   = 1'b1;
        wr_duty_i = W'(vals[i]);
        @(negedge clk);
      end
      wr_en_i = 1'b0;
      check(level_o == 4, "R4 queue full", int'(level_o), 4);
      check(ovf_o == 1, "R7 overflow set", int'(ovf_o), 1);
      wait_cnt0();
      for (int k = 0; k < 4; k++) begin
        check(level_o == LW'(3 - k), "R4 level per period", int'(level_o), 3 - k);
        measure(10, vals[k], "R4 fifo order");
      end
      measure(10, 9, "R7 dropped value never used");
    end
    check(ovf_o == 1, "R7 overflow sticky", int'(ovf_o), 1);
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    check(ovf_o == 0, "R7 overflow cleared", int'(ovf_o), 0);
    wait_cnt0();

    // R8: disable parks counter and output
    en_i = 1'b0;
    @(negedge clk);
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 5; i++) begin
        if (pwm_o || cnt_o != 0) ok = 1'b0;
        @(negedge clk);
      end
      check(ok, "R8 parked while disabled", int'(cnt_o), 0);
    end

    // R9: flush on enable, write in that cycle dropped, duty 9 kept
    wr_en_i = 1'b1; wr_duty_i = 16'd3; @(negedge clk);
    wr_duty_i = 16'd5; @(negedge clk);
    wr_en_i = 1'b0;
    check(level_o == 2, "R9 queued while disabled", int'(level_o), 2);
    en_i = 1'b1; wr_en_i = 1'b1; wr_duty_i = 16'd2;
    @(negedge clk);
    wr_en_i = 1'b0;
    check(level_o == 0, "R9 flushed on enable", int'(level_o), 0);
    check(ovf_o == 0, "R9 no overflow from flush cycle", int'(ovf_o), 0);
    check(cnt_o == 0, "R9 counter restarts", int'(cnt_o), 0);
    measure(10, 9, "R9 active duty kept");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule